// File: doc/BRIEF.md
# Bus Cycle Address Break Comparator

This block watches the bus cycles of a processor and raises a break condition when a cycle hits a programmed 24-bit address with a chosen kind of access. Software sets up a break address register and an 8-bit control register through a write-only register port. The control register holds three fields. A 3-bit mask code makes a fixed number of low address bits play no part in the comparison. A 2-bit cycle select picks the kind of bus cycle that can cause a break. An enable bit gates the interrupt request.

Each clock in which the bus reports a valid cycle is compared against the settings in force before that edge. On a hit, a sticky break flag is set on the following edge. It stays set until software pulses the clear input. The interrupt request is the flag gated by the enable bit. Both registers can be read back at dedicated outputs, so software can check its own setup.

Top module: `addr_break_unit`

## Requirements
- R1: After reset the break flag and interrupt request are 0, the control readback is 8'h00 (mask code 000, cycle select 00, enable 0), and the address readback is 24'h000000.
- R2: A register write (regSel 0 = address from regWrData[23:0], regSel 1 = control from regWrData[7:0]) shows at the readback after the next clock edge. A bus cycle on that same edge is compared with the previous settings.
- R3: The control mask code in bits 5..3 sets how many low address bits are ignored: 000→0, 001→1, 010→2, 011→3, 100→4, 101→8, 110→12, 111→16.
- R4: The control cycle select in bits 2..1 qualifies the match: 00 fetch (busFetch), 01 read (busRead), 10 write (busWrite), 11 read or write.
- R5: A cycle is compared only while busValid is 1. A qualifying cycle sets breakFlag on the clock edge that samples it.
- R6: breakFlag stays set until clearFlag is 1 at a clock edge. It then clears, unless a qualifying cycle is sampled on the same edge, in which case it stays set.
- R7: breakIrq equals breakFlag AND control bit 0. The flag is set regardless of the enable bit.
- R8: Control bits 7 and 6 always read as 0, whatever was written to them.
- R9: Every unmasked address bit must equal the break address for a match. A difference in any one of them gives no break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects break address, 1 selects control |
| regWrData | input | 24 | Write data |
| clearFlag | input | 1 | Pulse of 1 clears the break flag |
| busValid | input | 1 | Bus cycle valid strobe |
| busAddr | input | 24 | Bus cycle address |
| busFetch | input | 1 | Cycle is an instruction fetch |
| busRead | input | 1 | Cycle is a data read |
| busWrite | input | 1 | Cycle is a data write |
| addrRead | output | 24 | Break address readback |
| ctrlRead | output | 8 | Control register readback |
| breakFlag | output | 1 | Sticky break flag |
| breakIrq | output | 1 | Break interrupt request |

## Verification
A wrong mask length or a wrong comparison bit shows up as breakFlag rising, or failing to rise, one edge after a cycle whose address differs from the break address just above or just below the mask boundary. The bench probes both sides of that boundary for every code. A corrupted control field shows at ctrlRead one edge after the write, and as a wrong cycle-type response at the first following bus cycle. A flag state machine that forgets the set-over-clear priority, or that drops the flag too early, is exposed within one edge by a set-and-clear collision and by idle cycles after a hit.

// File: rtl/brk_pkg.sv
package brk_pkg;

  localparam int ADDR_W    = 24;
  localparam int CTRL_W    = 8;
  localparam int MASK_CODE_W = 3;
  localparam int SEL_W     = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_FETCH = 2'b00,
    SEL_READ  = 2'b01,
    SEL_WRITE = 2'b10,
    SEL_RDWR  = 2'b11
  } cycleSel_e;

  typedef struct packed {
    logic ldAddr;
    logic clrFlag;
    logic cycleHit;
  } brkStrobes_t;

  function automatic int maskWidth(input logic [MASK_CODE_W-1:0] code);
    int n;
    if (code <= 3'd4) n = int'(code);
    else              n = (int'(code) - 3) * 4;
    return n;
  endfunction

endpackage

// File: rtl/brk_ctrl.sv
module brk_ctrl
  import brk_pkg::*;
#(
  parameter int CW = brk_pkg::CTRL_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic                   regSel,
  input  logic [CW-1:0]          ctrlWrData,
  input  logic                   clearFlag,
  input  logic                   busValid,
  input  logic                   busFetch,
  input  logic                   busRead,
  input  logic                   busWrite,
  output logic [CW-1:0]          ctrlReg,
  output logic [MASK_CODE_W-1:0] maskCode,
  output logic                   irqEn,
  output brkStrobes_t            strobes
);

  localparam int SEL_LO  = 1;
  localparam int MASK_LO = SEL_LO + SEL_W;
  localparam int USED_W  = MASK_LO + MASK_CODE_W;

  cycleSel_e cycleSel;
  logic      typeOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskCode <= '0;
      cycleSel <= SEL_FETCH;
      irqEn    <= 1'b0;
    end else if (regWrEn && regSel) begin
      maskCode <= ctrlWrData[MASK_LO +: MASK_CODE_W];
      cycleSel <= cycleSel_e'(ctrlWrData[SEL_LO +: SEL_W]);
      irqEn    <= ctrlWrData[0];
    end
  end

  always_comb begin
    unique case (cycleSel)
      SEL_FETCH: typeOk = busFetch;
      SEL_READ:  typeOk = busRead;
      SEL_WRITE: typeOk = busWrite;
      default:   typeOk = busRead | busWrite;
    endcase
  end

  always_comb begin
    ctrlReg = '0;
    ctrlReg[USED_W-1:0] = {maskCode, cycleSel, irqEn};
  end

  assign strobes.ldAddr   = regWrEn & ~regSel;
  assign strobes.clrFlag  = clearFlag;
  assign strobes.cycleHit = busValid & typeOk;

endmodule

// File: rtl/brk_datapath.sv
module brk_datapath
  import brk_pkg::*;
#(
  parameter int AW = brk_pkg::ADDR_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [AW-1:0]          addrWrData,
  input  brkStrobes_t            strobes,
  input  logic [MASK_CODE_W-1:0] maskCode,
  input  logic                   irqEn,
  input  logic [AW-1:0]          busAddr,
  output logic [AW-1:0]          brkAddr,
  output logic                   breakFlag,
  output logic                   breakIrq
);

  localparam int LEN_W = $clog2(AW + 1);

  logic [LEN_W-1:0] maskLen;
  logic [AW-1:0]    maskVec;
  logic [AW-1:0]    bitOk;
  logic             addrHit;
  logic             setFlag;

  assign maskLen = LEN_W'(maskWidth(maskCode));

  for (genvar gi = 0; gi < AW; gi++) begin : g_bit
    assign maskVec[gi] = LEN_W'(gi) < maskLen;
    assign bitOk[gi]   = maskVec[gi] | ~(busAddr[gi] ^ brkAddr[gi]);
  end

  assign addrHit = &bitOk;
  assign setFlag = strobes.cycleHit & addrHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               brkAddr <= '0;
    else if (strobes.ldAddr) brkAddr <= addrWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                breakFlag <= 1'b0;
    else if (setFlag)         breakFlag <= 1'b1;
    else if (strobes.clrFlag) breakFlag <= 1'b0;
  end

  assign breakIrq = breakFlag & irqEn;

endmodule

// File: rtl/addr_break_unit.sv
module addr_break_unit
  import brk_pkg::*;
#(
  parameter int AW = brk_pkg::ADDR_W,
  parameter int CW = brk_pkg::CTRL_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic          regSel,
  input  logic [AW-1:0] regWrData,
  input  logic          clearFlag,
  input  logic          busValid,
  input  logic [AW-1:0] busAddr,
  input  logic          busFetch,
  input  logic          busRead,
  input  logic          busWrite,
  output logic [AW-1:0] addrRead,
  output logic [CW-1:0] ctrlRead,
  output logic          breakFlag,
  output logic          breakIrq
);

  brkStrobes_t            strobes;
  logic [MASK_CODE_W-1:0] maskCode;
  logic                   irqEn;

  brk_ctrl #(.CW(CW)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regSel     (regSel),
    .ctrlWrData (regWrData[CW-1:0]),
    .clearFlag  (clearFlag),
    .busValid   (busValid),
    .busFetch   (busFetch),
    .busRead    (busRead),
    .busWrite   (busWrite),
    .ctrlReg    (ctrlRead),
    .maskCode   (maskCode),
    .irqEn      (irqEn),
    .strobes    (strobes)
  );

  brk_datapath #(.AW(AW)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .addrWrData (regWrData),
    .strobes    (strobes),
    .maskCode   (maskCode),
    .irqEn      (irqEn),
    .busAddr    (busAddr),
    .brkAddr    (addrRead),
    .breakFlag  (breakFlag),
    .breakIrq   (breakIrq)
  );

endmodule

// File: rtl/brk_checker.sv
module brk_checker #(
  parameter int AW = 24,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          regWrEn,
  input logic          regSel,
  input logic [AW-1:0] regWrData,
  input logic          clearFlag,
  input logic          busValid,
  input logic [AW-1:0] busAddr,
  input logic          busFetch,
  input logic [AW-1:0] addrRead,
  input logic [CW-1:0] ctrlRead,
  input logic          breakFlag,
  input logic          breakIrq
);

  // R6: flag holds without a clear
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    breakFlag && !clearFlag |=> breakFlag);

  // R6: a clear with no bus cycle drops the flag
  p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    clearFlag && !busValid |=> !breakFlag);

  // R5: no valid cycle, no new flag
  p_no_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    !breakFlag && !busValid |=> !breakFlag);

  // R7: request only with a flag
  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    breakIrq |-> breakFlag);

  // R8: reserved control bits stay zero
  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRead[CW-1:CW-2] == 2'b00);

  // R2: address write lands after one edge
  p_addr_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && !regSel |=> addrRead == $past(regWrData));

  // R9: full-address fetch hit with default-style control sets the flag
  p_full_hit_r9: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busFetch && ctrlRead[5:1] == 5'd0 && busAddr == addrRead
    |=> breakFlag);

endmodule

bind addr_break_unit brk_checker #(.AW(AW), .CW(CW)) i_brk_checker (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regSel    (regSel),
  .regWrData (regWrData),
  .clearFlag (clearFlag),
  .busValid  (busValid),
  .busAddr   (busAddr),
  .busFetch  (busFetch),
  .addrRead  (addrRead),
  .ctrlRead  (ctrlRead),
  .breakFlag (breakFlag),
  .breakIrq  (breakIrq)
);

// File: tb/test_addr_break_unit.sv
module test_addr_break_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn, regSel, clearFlag;
  logic [23:0] regWrData;
  logic        busValid, busFetch, busRead, busWrite;
  logic [23:0] busAddr;
  logic [23:0] addrRead;
  logic [7:0]  ctrlRead;
  logic        breakFlag, breakIrq;

  int checkCnt = 0;
  int failCnt  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  addr_break_unit i_addr_break_unit (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .clearFlag(clearFlag), .busValid(busValid),
    .busAddr(busAddr), .busFetch(busFetch), .busRead(busRead),
    .busWrite(busWrite), .addrRead(addrRead), .ctrlRead(ctrlRead),
    .breakFlag(breakFlag), .breakIrq(breakIrq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idleInputs();
    regWrEn = 0; regSel = 0; regWrData = '0; clearFlag = 0;
    busValid = 0; busAddr = '0; busFetch = 0; busRead = 0; busWrite = 0;
  endtask

  task automatic writeReg(input logic sel, input logic [23:0] data);
    regWrEn = 1; regSel = sel; regWrData = data;
    tick();
    regWrEn = 0;
  endtask

  task automatic doClear();
    clearFlag = 1;
    tick();
    clearFlag = 0;
  endtask

  task automatic busCycle(input logic [23:0] a, input logic f, input logic r, input logic w);
    busValid = 1; busAddr = a; busFetch = f; busRead = r; busWrite = w;
    tick();
    busValid = 0; busFetch = 0; busRead = 0; busWrite = 0;
  endtask

  task automatic t_reset();
    check("R1 flag", 32'(breakFlag), 0);
    check("R1 irq", 32'(breakIrq), 0);
    check("R1 ctrl", 32'(ctrlRead), 0);
    check("R1 addr", 32'(addrRead), 0);
  endtask

  task automatic t_regs();
    writeReg(1'b1, 24'h0000FF);
    check("R8 reserved bits", 32'(ctrlRead), 32'h3F);
    writeReg(1'b1, 24'h000000);
    check("R2 ctrl write", 32'(ctrlRead), 0);
    writeReg(1'b0, 24'h5A5A5A);
    check("R2 addr write", 32'(addrRead), 32'h5A5A5A);
  endtask

  task automatic t_full_match();
    writeReg(1'b1, 24'h0);
    writeReg(1'b0, 24'h123456);
    busCycle(24'h123457, 1, 0, 0);
    check("R9 bit0 differs", 32'(breakFlag), 0);
    busCycle(24'h923456, 1, 0, 0);
    check("R9 bit23 differs", 32'(breakFlag), 0);
    busValid = 0; busAddr = 24'h123456; busFetch = 1;
    tick();
    busFetch = 0;
    check("R5 no valid", 32'(breakFlag), 0);
    busCycle(24'h123456, 1, 0, 0);
    check("R5 hit sets flag", 32'(breakFlag), 1);
    repeat (3) tick();
    check("R6 sticky", 32'(breakFlag), 1);
  endtask

  task automatic t_clear();
    doClear();
    check("R6 clear", 32'(breakFlag), 0);
    busCycle(24'h123456, 1, 0, 0);
    clearFlag = 1; busValid = 1; busAddr = 24'h123456; busFetch = 1;
    tick();
    clearFlag = 0; busValid = 0; busFetch = 0;
    check("R6 set beats clear", 32'(breakFlag), 1);
    doClear();
    check("R6 clear again", 32'(breakFlag), 0);
  endtask

  task automatic t_mask();
    int widths[8] = '{0, 1, 2, 3, 4, 8, 12, 16};
    logic [23:0] base = 24'hA5C3E7;
    writeReg(1'b0, base);
    for (int c = 0; c < 8; c++) begin
      int n = widths[c];
      writeReg(1'b1, 24'(c << 3));
      if (n > 0) begin
        busCycle(base ^ ((24'd1 << n) - 24'd1), 1, 0, 0);
        check($sformatf("R3 code %0d masked hit", c), 32'(breakFlag), 1);
        doClear();
      end
      busCycle(base ^ (24'd1 << n), 1, 0, 0);
      check($sformatf("R3 code %0d first kept bit", c), 32'(breakFlag), 0);
      doClear();
    end
  endtask

  task automatic t_types();
    writeReg(1'b0, 24'h00C0DE);
    for (int s = 0; s < 4; s++) begin
      writeReg(1'b1, 24'(s << 1));
      for (int k = 0; k < 3; k++) begin
        logic exp;
        case (s)
          0: exp = (k == 0);
          1: exp = (k == 1);
          2: exp = (k == 2);
          default: exp = (k != 0);
        endcase
        busCycle(24'h00C0DE, k == 0, k == 1, k == 2);
        check($sformatf("R4 sel %0d kind %0d", s, k), 32'(breakFlag), 32'(exp));
        doClear();
      end
    end
  endtask

  task automatic t_irq();
    writeReg(1'b1, 24'h0);
    busCycle(24'h00C0DE, 1, 0, 0);
    check("R7 flag while disabled", 32'(breakFlag), 1);
    check("R7 irq disabled", 32'(breakIrq), 0);
    writeReg(1'b1, 24'h1);
    check("R7 irq enabled", 32'(breakIrq), 1);
    doClear();
    check("R7 irq drops with flag", 32'(breakIrq), 0);
  endtask

  task automatic t_same_edge();
    writeReg(1'b1, 24'h0);
    writeReg(1'b0, 24'h111111);
    regWrEn = 1; regSel = 0; regWrData = 24'h222222;
    busValid = 1; busAddr = 24'h111111; busFetch = 1;
    tick();
    regWrEn = 0; busValid = 0; busFetch = 0;
    check("R2 old address used", 32'(breakFlag), 1);
    doClear();
    regWrEn = 1; regSel = 1; regWrData = 24'h38;
    busValid = 1; busAddr = 24'h222200; busFetch = 1;
    tick();
    regWrEn = 0; busValid = 0; busFetch = 0;
    check("R2 old mask used", 32'(breakFlag), 0);
    busCycle(24'h222200, 1, 0, 0);
    check("R2 new mask after edge", 32'(breakFlag), 1);
    doClear();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    idleInputs();
    rstN = 0;
    repeat (2) tick();
    rstN = 1;
    tick();
    t_reset();
    t_regs();
    t_full_match();
    t_clear();
    t_mask();
    t_types();
    t_irq();
    t_same_edge();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

endmodule